// File: doc/BRIEF.md
# Gapped Nibble Payload Ingress

This block takes outbound DS3 payload from terminal equipment four bits at a time and turns it into a serial payload stream for the transmit framer. It runs on the line-rate transmit clock. It hands the equipment a one-cycle nibble strobe that comes nominally every four line clocks. The strobe is held back by one extra clock wherever the frame carries an overhead bit, so the equipment is only asked for payload. The frame is modelled as 56 blocks of 85 bit slots. The last slot of every block is overhead and the other 84 are payload, which gives 1176 nibbles per frame.

Each nibble is sampled at a fixed offset after its strobe, held, and shifted out most significant bit first. A payload-valid flag marks the payload slots and a frame-start flag marks slot 0. An external framing reference pins the frame phase: its rising edge is taken as the strobe of the frame's first nibble. If the reference disagrees with the free-running count, the count is moved to match it and a sticky flag records the event. A clear input drops that flag.

Top module: `nibgap_ingress`

## Requirements
- R1: While `rst_n` is low (with `frame_ref_i` low), the frame position is 0. In that state `nib_strobe_o` = 0, `ser_data_o` = 0, `frame_start_o` = 1, `payload_vld_o` = 1 and `misalign_o` = 0.
- R2: Frame position P runs 0..4759 and then wraps. Block slot = P mod 85. `payload_vld_o` is 0 when the block slot is 84 and 1 otherwise, which gives 4704 valid slots per frame. `frame_start_o` is high for exactly one cycle per frame, at P = 0.
- R3: A nibble starts at every P whose block slot is below 84 and divisible by 4. `nib_strobe_o` is high for one cycle exactly three cycles before each nibble start. That gives 1176 strobes per frame, spaced 4 cycles apart except once per block, where the spacing is 5 (56 times per frame).
- R4: `tx_nib_i` is captured on the rising edge that ends the cycle just before the nibble start. That edge is the third rising edge counted from the edge that ends the strobe cycle. The value of `tx_nib_i` in any other cycle has no effect.
- R5: During the four payload slots of a nibble, `ser_data_o` carries bit 3, bit 2, bit 1, bit 0 of the captured nibble, in that order. In overhead slots `ser_data_o` is 0.
- R6: A rising edge of `frame_ref_i` marks its cycle as the strobe cycle of the frame's first nibble (P = 4757). `nib_strobe_o` is high in that cycle, and `frame_start_o` rises three cycles later. If the count was elsewhere, it is moved so that the next cycle is P = 4758.
- R7: Until the first reference edge after reset, the position counts freely from 0, with the same strobe and overhead pattern.
- R8: `misalign_o` goes high in the cycle after a reference rising edge that arrives at any P other than 4757. The first edge after reset never sets it, and an edge at P = 4757 never sets it.
- R9: `misalign_o` stays high until a cycle with `misalign_clr_i` = 1, after which it is 0. If a misaligned edge arrives in the same cycle as the clear, the flag stays set.
- R10: Only the rising edge of `frame_ref_i` counts. Holding it high for many cycles causes no further realignment, and the overhead slot at block slot 84 still appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-rate transmit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_nib_i | input | NIB_W (4) | Payload nibble from the terminal equipment |
| frame_ref_i | input | 1 | Framing reference; rising edge marks the first nibble's strobe cycle |
| misalign_clr_i | input | 1 | Clears the misalignment flag |
| nib_strobe_o | output | 1 | Gapped nibble strobe to the equipment |
| ser_data_o | output | 1 | Serial payload bit, MSB of each nibble first |
| payload_vld_o | output | 1 | High in payload slots, low in overhead slots |
| frame_start_o | output | 1 | One-cycle pulse at frame position 0 |
| misalign_o | output | 1 | Sticky flag: reference arrived off the expected position |

## Verification
The hardest case to reach from the ports is a reference edge in the exact cycle the counter reaches the wrap position, together with a clear that lands in the same cycle as a misaligned edge. The bench keeps its own model of the frame position, so it can walk the count to any chosen position, such as 4757, 2000 or 3000, before it raises the reference. It also limits the equipment's nibble to a single valid cycle, with the inverted value driven in the cycles around it, so that a capture on the wrong edge corrupts the serial stream.

// File: rtl/nibgap_pkg.sv
package nibgap_pkg;
  // Default frame geometry: payload slots per block, blocks per frame,
  // nibble width and the strobe-to-first-bit lead in line clocks.
  localparam int NIB_BITS    = 4;
  localparam int PAY_PER_BLK = 84;
  localparam int BLK_PER_FRM = 56;
  localparam int STROBE_LEAD = 3;
endpackage

// File: rtl/nibgap_pos_ctr.sv
module nibgap_pos_ctr #(
  parameter int BLK_LEN = 85,
  parameter int BLOCKS  = 56,
  parameter int REF_B   = 82,
  parameter int BW      = 7,
  parameter int KW      = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  output logic [BW-1:0] blk_bit_o,
  output logic [KW-1:0] blk_idx_o
);
  logic [BW-1:0] blk_bit_q, blk_bit_d, b_src;
  logic [KW-1:0] blk_idx_q, blk_idx_d, k_src;

  // Next state: a load lands on the slot after the reference slot.
  always_comb begin
    b_src = load_i ? BW'(REF_B) : blk_bit_q;
    k_src = load_i ? KW'(BLOCKS - 1) : blk_idx_q;
    if (b_src == BW'(BLK_LEN - 1)) begin
      blk_bit_d = '0;
      blk_idx_d = (k_src == KW'(BLOCKS - 1)) ? '0 : k_src + KW'(1);
    end else begin
      blk_bit_d = b_src + BW'(1);
      blk_idx_d = k_src;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_bit_q <= '0;
      blk_idx_q <= '0;
    end else begin
      blk_bit_q <= blk_bit_d;
      blk_idx_q <= blk_idx_d;
    end
  end

  assign blk_bit_o = blk_bit_q;
  assign blk_idx_o = blk_idx_q;

  // R2: slot and block indices stay inside the frame geometry
  a_r2_pos_range: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_bit_q < BW'(BLK_LEN)) && (blk_idx_q < KW'(BLOCKS)));

  // R2: the overhead slot is always followed by slot 0 of a block
  a_r2_block_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && blk_bit_q == BW'(BLK_LEN - 1)) |=> (blk_bit_q == '0));
endmodule

// File: rtl/nibgap_sampler.sv
module nibgap_sampler #(
  parameter int NIB_W    = 4,
  parameter int PAY_BITS = 84,
  parameter int BLK_LEN  = 85,
  parameter int LAG      = 3,
  parameter int BW       = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BW-1:0]    blk_bit_i,
  input  logic             force_strobe_i,
  input  logic [NIB_W-1:0] nib_i,
  output logic             strobe_o,
  output logic             ser_o,
  output logic             vld_o
);
  localparam int SW = (NIB_W > 1) ? $clog2(NIB_W) : 1;

  logic [BW-1:0]    ahead_lag, ahead_one;
  logic             dec_strobe, cap_en;
  logic [SW-1:0]    bit_idx;
  logic [NIB_W-1:0] nib_q, nib_d;

  function automatic logic nib_first(input logic [BW-1:0] slot);
    return (slot < BW'(PAY_BITS)) && ((slot % BW'(NIB_W)) == '0);
  endfunction

  // Look ahead within the block: strobe LAG slots early, capture one early.
  always_comb begin
    ahead_lag = blk_bit_i + BW'(LAG);
    if (ahead_lag >= BW'(BLK_LEN)) ahead_lag = ahead_lag - BW'(BLK_LEN);
    ahead_one = blk_bit_i + BW'(1);
    if (ahead_one >= BW'(BLK_LEN)) ahead_one = ahead_one - BW'(BLK_LEN);
    dec_strobe = nib_first(ahead_lag);
    cap_en     = nib_first(ahead_one);
    nib_d      = cap_en ? nib_i : nib_q;
    bit_idx    = SW'(NIB_W - 1) - SW'(blk_bit_i % BW'(NIB_W));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nib_q <= '0;
    else        nib_q <= nib_d;
  end

  assign strobe_o = dec_strobe | force_strobe_i;
  assign vld_o    = blk_bit_i < BW'(PAY_BITS);
  assign ser_o    = vld_o & nib_q[bit_idx];

  // R3: position-decoded strobes are never back to back
  a_r3_strobe_apart: assert property (@(posedge clk) disable iff (!rst_n)
    dec_strobe |=> !dec_strobe);

  // R5: the held nibble does not change while its bits are shifting out
  a_r5_nibble_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && (blk_bit_i % BW'(NIB_W)) != '0) |-> $stable(nib_q));
endmodule

// File: rtl/nibgap_ingress.sv
module nibgap_ingress
  import nibgap_pkg::*;
#(
  parameter int NIB_W    = NIB_BITS,
  parameter int PAY_BITS = PAY_PER_BLK,
  parameter int BLOCKS   = BLK_PER_FRM,
  parameter int LAG      = STROBE_LEAD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NIB_W-1:0] tx_nib_i,
  input  logic             frame_ref_i,
  input  logic             misalign_clr_i,
  output logic             nib_strobe_o,
  output logic             ser_data_o,
  output logic             payload_vld_o,
  output logic             frame_start_o,
  output logic             misalign_o
);
  localparam int BLK_LEN = PAY_BITS + 1;
  localparam int BW      = $clog2(BLK_LEN + LAG + 1);
  localparam int KW      = $clog2(BLOCKS + 1);
  localparam int REF_B   = BLK_LEN - LAG;

  logic [BW-1:0] blk_bit;
  logic [KW-1:0] blk_idx;
  logic          ref_q, locked_q, mis_q;
  logic          ref_d, locked_d, mis_d;
  logic          rise, at_ref, load, off_edge;

  always_comb begin
    rise     = frame_ref_i & ~ref_q;
    at_ref   = (blk_bit == BW'(REF_B)) && (blk_idx == KW'(BLOCKS - 1));
    load     = rise & ~at_ref;
    off_edge = load & locked_q;
    ref_d    = frame_ref_i;
    locked_d = locked_q | rise;
    if (off_edge)            mis_d = 1'b1;
    else if (misalign_clr_i) mis_d = 1'b0;
    else                     mis_d = mis_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q    <= 1'b0;
      locked_q <= 1'b0;
      mis_q    <= 1'b0;
    end else begin
      ref_q    <= ref_d;
      locked_q <= locked_d;
      mis_q    <= mis_d;
    end
  end

  nibgap_pos_ctr #(
    .BLK_LEN(BLK_LEN), .BLOCKS(BLOCKS), .REF_B(REF_B), .BW(BW), .KW(KW)
  ) u_pos (
    .clk(clk), .rst_n(rst_n), .load_i(load),
    .blk_bit_o(blk_bit), .blk_idx_o(blk_idx)
  );

  nibgap_sampler #(
    .NIB_W(NIB_W), .PAY_BITS(PAY_BITS), .BLK_LEN(BLK_LEN), .LAG(LAG), .BW(BW)
  ) u_smp (
    .clk(clk), .rst_n(rst_n), .blk_bit_i(blk_bit), .force_strobe_i(rise),
    .nib_i(tx_nib_i), .strobe_o(nib_strobe_o), .ser_o(ser_data_o),
    .vld_o(payload_vld_o)
  );

  assign frame_start_o = (blk_bit == '0) && (blk_idx == '0);
  assign misalign_o    = mis_q;

  // R6: an isolated reference edge leads to frame start three cycles later
  a_r6_ref_to_start: assert property (@(posedge clk) disable iff (!rst_n)
    rise ##1 !rise ##1 !rise |-> ##1 frame_start_o);

  // R8: the flag only rises after an off-position edge while locked
  a_r8_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(misalign_o) |-> $past(rise && locked_q && !at_ref));

  // R9: a clear without a competing off-position edge drops the flag
  a_r9_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (misalign_clr_i && !(rise && locked_q && !at_ref)) |=> !misalign_o);
endmodule

// File: tb/sim_nibgap_ingress.sv
module sim_nibgap_ingress;
  localparam int FRAME = 4760;
  localparam int BLK   = 85;
  localparam int PAY   = 84;
  localparam int NV    = 14;
  // {position[12:0], strobe, valid, frame_start}
  localparam logic [15:0] VEC [NV] = '{
    {13'd0,    3'b011}, {13'd1,    3'b110}, {13'd2,    3'b010},
    {13'd3,    3'b010}, {13'd5,    3'b110}, {13'd77,   3'b110},
    {13'd81,   3'b010}, {13'd82,   3'b110}, {13'd84,   3'b000},
    {13'd85,   3'b010}, {13'd86,   3'b110}, {13'd4757, 3'b110},
    {13'd4758, 3'b010}, {13'd4759, 3'b000}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] tx_nib = 4'h0;
  logic       frame_ref = 1'b0;
  logic       misalign_clr = 1'b0;
  logic       nib_strobe, ser_data, payload_vld, frame_start, misalign;

  int checks = 0, errors = 0;
  int p = 0, p_nxt = 0;
  logic ref_prev = 1'b0;
  logic [3:0] cap_m = 4'h0, te_val = 4'h3;
  int te_age = 9, nib_ctr = 0;
  bit chk_on = 0, tbl_on = 0;
  int mm_strobe = 0, mm_vld = 0, mm_fs = 0, mm_ser = 0, mm_ovh = 0;
  int n_strobe = 0, n_vld = 0, n_fs = 0, n_four = 0, n_five = 0, last_s = -1, cyc_no = 0;

  always #5 clk = ~clk;

  nibgap_ingress u0 (
    .clk(clk), .rst_n(rst_n), .tx_nib_i(tx_nib), .frame_ref_i(frame_ref),
    .misalign_clr_i(misalign_clr), .nib_strobe_o(nib_strobe),
    .ser_data_o(ser_data), .payload_vld_o(payload_vld),
    .frame_start_o(frame_start), .misalign_o(misalign)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit nib_start(input int q);
    return ((q % BLK) < PAY) && (((q % BLK) % 4) == 0);
  endfunction

  task automatic cyc(input logic ref_v, input logic clr_v);
    logic rise, s_exp, v_exp, f_exp, d_exp;
    @(posedge clk); #1;
    p = p_nxt;
    cyc_no++;
    if (te_age < 9) te_age++;
    frame_ref    = ref_v;
    misalign_clr = clr_v;
    tx_nib       = (te_age == 2) ? te_val : ~te_val;
    rise  = ref_v && !ref_prev;
    s_exp = rise || nib_start((p + 3) % FRAME);
    v_exp = (p % BLK) < PAY;
    f_exp = (p == 0);
    d_exp = v_exp ? cap_m[3 - ((p % BLK) % 4)] : 1'b0;
    @(negedge clk);
    if (chk_on) begin
      if (nib_strobe !== s_exp) mm_strobe++;
      if (payload_vld !== v_exp) mm_vld++;
      if (frame_start !== f_exp) mm_fs++;
      if (ser_data !== d_exp) begin
        if (v_exp) mm_ser++; else mm_ovh++;
      end
    end
    if (tbl_on) begin
      for (int i = 0; i < NV; i++) begin
        if (p == int'(VEC[i][15:3])) begin
          chk("R3", $sformatf("strobe at P=%0d", p), int'(nib_strobe), int'(VEC[i][2]));
          chk("R2", $sformatf("valid at P=%0d", p), int'(payload_vld), int'(VEC[i][1]));
          chk("R2", $sformatf("frame_start at P=%0d", p), int'(frame_start), int'(VEC[i][0]));
        end
      end
      if (nib_strobe) begin
        n_strobe++;
        if (last_s >= 0) begin
          if (cyc_no - last_s == 4) n_four++;
          else if (cyc_no - last_s == 5) n_five++;
        end
        last_s = cyc_no;
      end
      if (payload_vld) n_vld++;
      if (frame_start) n_fs++;
    end
    // equipment model reacts to the observed strobe
    if (nib_strobe) begin
      te_age = 0;
      te_val = 4'(nib_ctr * 5 + 3);
      nib_ctr++;
    end
    // R4: capture on the edge ending the cycle before a nibble start
    if (nib_start((p + 1) % FRAME)) cap_m = tx_nib;
    ref_prev = ref_v;
    p_nxt = rise ? 4758 : (p + 1) % FRAME;
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0; frame_ref = 1'b0; misalign_clr = 1'b0; chk_on = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1", "strobe in reset", int'(nib_strobe), 0);
    chk("R1", "ser_data in reset", int'(ser_data), 0);
    chk("R1", "frame_start in reset", int'(frame_start), 1);
    chk("R1", "valid in reset", int'(payload_vld), 1);
    chk("R1", "misalign in reset", int'(misalign), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    p_nxt = 1; ref_prev = 1'b0; cap_m = 4'h0; te_age = 9; chk_on = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R7 free run over one full frame, vector table walked per cycle
    tbl_on = 1;
    for (int i = 0; i < FRAME; i++) cyc(1'b0, 1'b0);
    tbl_on = 0;
    chk("R3", "strobes per frame", n_strobe, 1176);
    chk("R3", "4-cycle spacings", n_four, 1119);
    chk("R3", "5-cycle spacings", n_five, 56);
    chk("R2", "valid slots per frame", n_vld, 4704);
    chk("R7", "frame starts in free-run frame", n_fs, 1);
    // second frame of payload with a single-cycle valid nibble window
    for (int i = 0; i < FRAME; i++) cyc(1'b0, 1'b0);

    // R6 first reference edge, off position
    while (p_nxt != 1000) cyc(1'b0, 1'b0);
    cyc(1'b1, 1'b0);
    chk("R6", "strobe in reference edge cycle", int'(nib_strobe), 1);
    cyc(1'b1, 1'b0);
    cyc(1'b1, 1'b0);
    cyc(1'b1, 1'b0);
    chk("R6", "frame_start three cycles after edge", int'(frame_start), 1);
    chk("R8", "first edge after reset sets no flag", int'(misalign), 0);
    // R10 level held high: overhead slot still appears at slot 84
    while (p_nxt != 84) cyc(1'b1, 1'b0);
    cyc(1'b1, 1'b0);
    chk("R10", "valid at slot 84 with reference held", int'(payload_vld), 0);
    cyc(1'b0, 1'b0);

    // R8 edge exactly at the expected position
    while (p_nxt != 4757) cyc(1'b0, 1'b0);
    cyc(1'b1, 1'b0);
    cyc(1'b0, 1'b0);
    chk("R8", "aligned edge sets no flag", int'(misalign), 0);
    cyc(1'b0, 1'b0);
    cyc(1'b0, 1'b0);
    chk("R6", "aligned edge keeps frame start", int'(frame_start), 1);

    // R8 off-position edge
    while (p_nxt != 2000) cyc(1'b0, 1'b0);
    cyc(1'b1, 1'b0);
    cyc(1'b0, 1'b0);
    chk("R8", "off-position edge sets flag", int'(misalign), 1);
    for (int i = 0; i < 20; i++) cyc(1'b0, 1'b0);
    chk("R9", "flag is sticky", int'(misalign), 1);
    // R9 clear, then set wins over clear
    cyc(1'b0, 1'b1);
    cyc(1'b0, 1'b0);
    chk("R9", "clear drops flag", int'(misalign), 0);
    while (p_nxt != 3000) cyc(1'b0, 1'b0);
    cyc(1'b1, 1'b1);
    cyc(1'b0, 1'b0);
    chk("R9", "set wins over clear", int'(misalign), 1);
    for (int i = 0; i < 300; i++) cyc(1'b0, 1'b0);

    // R1 reset in mid-run clears flag and position
    do_reset();
    for (int i = 0; i < 400; i++) cyc(1'b0, 1'b0);

    chk("R3", "strobe mismatches vs model", mm_strobe, 0);
    chk("R2", "valid mismatches vs model", mm_vld, 0);
    chk("R2", "frame_start mismatches vs model", mm_fs, 0);
    chk("R4", "R5 payload bit mismatches vs model", mm_ser, 0);
    chk("R5", "nonzero data in overhead slots", mm_ovh, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule